// File: doc/BRIEF.md
# Dual-Clock Power Mode Controller

This block sequences the power modes of a small controller that has a fast and a slow oscillator. Software writes one control word. Its bits turn each oscillator on or off, pick which one drives the system clock, and request one of two idle depths. The block keeps the enable and select outputs consistent with a six-mode map. It refuses any write that would leave the selected clock without a running oscillator, and it records each refused write in a sticky error flag.

Clock source changes never glitch. The controller waits for the outgoing clock to be low, then gates the clock. It changes the select output only after the incoming clock is seen low. Light idle halts the CPU but keeps the peripherals clocked, and any interrupt ends it. Deep idle also cuts the peripheral clock, and only a falling edge of the time-base source clock ends it. After deep idle the controller comes back in fast single-clock mode and can then post a time-base interrupt. A machine-cycle tick marks every fourth rising edge of the selected clock.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset, mode is 0 (fast single-clock), fosc_en=1, sosc_en=0, clk_sel=0, cpu_clk_en=1, per_clk_en=1 and err_sticky=0. Mode codes are: 0 fast single-clock, 1 fast dual-clock, 2 slow with both oscillators, 3 slow with fast oscillator off, 4 light idle, 5 deep idle.
- R2: The control word has these bits: bit0 fast oscillator enable, bit1 slow oscillator enable, bit2 select slow clock, bit3 light idle, bit4 deep idle, bit5 time-base enable. In a normal mode, a write of 0x03 gives mode 1 with sosc_en=1. A write of 0x01 from mode 1 gives mode 0.
- R3: In mode 1, a write with bit2=1 (0x07) moves to mode 2 once the switch completes. In mode 2, a write of 0x03 returns to mode 1.
- R4: clk_sel does not change in the cycle after the write. It changes only after a gap in which cpu_clk_en=0, and only when the incoming clock level was 0 in the previous cycle.
- R5: In mode 2, clearing bit0 (write 0x06) moves to mode 3 with fosc_en=0.
- R6: A write is ignored and sets err_sticky in any of these cases: it leaves the selected clock's oscillator off; it selects a clock whose oscillator was off; it changes the select bit together with an enable; it arrives during a switch or in an idle mode; it requests deep idle from a slow mode. err_sticky stays set until reset.
- R7: Bit3 (with bit4 clear) enters mode 4 with cpu_clk_en=0 and per_clk_en=1, and the oscillator state is kept.
- R8: In mode 4, irq_any returns to the previous mode in the next cycle. With ime=1, wake_service pulses for one cycle; with ime=0, wake_resume pulses for one cycle.
- R9: Bit4 from mode 0 or 1 enters mode 5 with cpu_clk_en=0 and per_clk_en=0. The oscillator enables are unchanged.
- R10: Mode 5 ignores irq_any and rising edges of tbt_src_lvl. A falling edge of tbt_src_lvl returns it to mode 0 with sosc_en=0.
- R11: tbt_irq_set pulses for one cycle, one cycle after the return from mode 5. It pulses only if bit5 was 1 in the write that entered mode 5.
- R12: While cpu_clk_en=1, mcyc_tick pulses once per 4 rising edges of the selected clock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 6 | Control word |
| fclk_lvl | input | 1 | Sampled level of the fast oscillator |
| sclk_lvl | input | 1 | Sampled level of the slow oscillator |
| tbt_src_lvl | input | 1 | Level of the selected time-base source clock |
| irq_any | input | 1 | Any enabled interrupt or wake request |
| ime | input | 1 | Interrupt master enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| fosc_en | output | 1 | Fast oscillator enable |
| sosc_en | output | 1 | Slow oscillator enable |
| clk_sel | output | 1 | System clock select, 1 = slow |
| mode | output | 3 | Current mode code |
| wake_service | output | 1 | Pulse: wake from light idle into interrupt service |
| wake_resume | output | 1 | Pulse: wake from light idle at the next instruction |
| tbt_irq_set | output | 1 | Pulse: set the time-base interrupt latch |
| err_sticky | output | 1 | A write was refused since reset |
| mcyc_tick | output | 1 | Machine cycle tick |

## Verification
A wrong run state shows on the clock enables or on the mode code at the first sample after the edge that caused it. A missed deep-idle exit leaves both enables low after the timer edge. A wrong switch phase either moves clk_sel in the cycle after the write or never opens the cpu_clk_en gap. A bad legality decision shows one cycle after the write, as a changed enable together with err_sticky still low, or the reverse. A lost deep-idle arm shows two cycles after the timer edge, as a missing or extra tbt_irq_set pulse.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  localparam int unsigned CB_FAST = 0;
  localparam int unsigned CB_SLOW = 1;
  localparam int unsigned CB_SEL  = 2;
  localparam int unsigned CB_NAP  = 3;
  localparam int unsigned CB_DEEP = 4;
  localparam int unsigned CB_TBT  = 5;

  typedef enum logic [2:0] {
    MD_RUN_FAST  = 3'd0,
    MD_RUN_DUAL  = 3'd1,
    MD_SLOW_BOTH = 3'd2,
    MD_SLOW_LP   = 3'd3,
    MD_NAP       = 3'd4,
    MD_DEEP      = 3'd5
  } mode_t;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_NAP  = 2'd1,
    ST_DEEP = 2'd2
  } run_st_t;

  typedef enum logic [1:0] {
    SW_STEADY = 2'd0,
    SW_DRAIN  = 2'd1,
    SW_GAP    = 2'd2
  } sw_ph_t;
endpackage

// File: rtl/pm_edge_det.sv
module pm_edge_det #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = lvl_q & ~lvl;
    end else begin : g_rise
      assign pulse = ~lvl_q & lvl;
    end
  endgenerate
endmodule

// File: rtl/pm_clk_switch.sv
module pm_clk_switch
  import pwrmode_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_sel,
  input  logic fclk_lvl,
  input  logic sclk_lvl,
  output logic sel,
  output logic gap,
  output logic busy
);
  sw_ph_t ph;
  logic   old_lvl;
  logic   new_lvl;

  assign old_lvl = sel ? sclk_lvl : fclk_lvl;
  assign new_lvl = sel ? fclk_lvl : sclk_lvl;
  assign gap     = (ph == SW_GAP);
  assign busy    = (ph != SW_STEADY) || (req_sel != sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= SW_STEADY;
      sel <= 1'b0;
    end else begin
      case (ph)
        SW_STEADY: if (req_sel != sel) ph <= SW_DRAIN;
        SW_DRAIN:  if (!old_lvl) ph <= SW_GAP;
        SW_GAP: begin
          if (!new_lvl) begin
            sel <= ~sel;
            ph  <= SW_STEADY;
          end
        end
        default:   ph <= SW_STEADY;
      endcase
    end
  end
endmodule

// File: rtl/pm_wr_check.sv
module pm_wr_check
  import pwrmode_pkg::*;
#(
  parameter int unsigned CTL_W = 6
) (
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             cur_f,
  input  logic             cur_s,
  input  logic             cur_sel,
  input  logic             running,
  input  logic             busy,
  output logic             go_deep,
  output logic             go_nap,
  output logic             go_clk,
  output logic             tbt_bit,
  output logic             illegal
);
  logic nf, ns, nsel, bad_clk;

  assign nf      = wr_data[CB_FAST];
  assign ns      = wr_data[CB_SLOW];
  assign nsel    = wr_data[CB_SEL];
  assign tbt_bit = wr_data[CB_TBT];

  always_comb begin
    bad_clk = (!nf && !nsel) || (!ns && nsel)
            || ((nsel != cur_sel) && ((nf != cur_f) || (ns != cur_s)))
            || (nsel && !cur_sel && !cur_s)
            || (!nsel && cur_sel && !cur_f);
    go_deep = 1'b0;
    go_nap  = 1'b0;
    go_clk  = 1'b0;
    illegal = 1'b0;
    if (wr_en) begin
      if (!running || busy)            illegal = 1'b1;
      else if (wr_data[CB_DEEP]) begin
        if (cur_sel)                   illegal = 1'b1;
        else                           go_deep = 1'b1;
      end
      else if (wr_data[CB_NAP])        go_nap  = 1'b1;
      else if (bad_clk)                illegal = 1'b1;
      else                             go_clk  = 1'b1;
    end
  end
endmodule

// File: rtl/pm_mcycle.sv
module pm_mcycle #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic lvl,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic          rise;
  logic [CW-1:0] cnt;

  pm_edge_det #(.FALLING(1'b0)) u_rise (
    .clk(clk), .rst(rst), .lvl(lvl), .pulse(rise)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (rise) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int unsigned CTL_W    = 6,
  parameter int unsigned MCYC_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             fclk_lvl,
  input  logic             sclk_lvl,
  input  logic             tbt_src_lvl,
  input  logic             irq_any,
  input  logic             ime,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             fosc_en,
  output logic             sosc_en,
  output logic             clk_sel,
  output logic [2:0]       mode,
  output logic             wake_service,
  output logic             wake_resume,
  output logic             tbt_irq_set,
  output logic             err_sticky,
  output logic             mcyc_tick
);
  run_st_t st;
  mode_t   mode_q;
  logic    req_sel, sw_gap, sw_busy;
  logic    go_deep, go_nap, go_clk, tbt_bit, illegal;
  logic    tbt_fall, tbt_arm, tbt_pend;

  pm_clk_switch u_sw (
    .clk(clk), .rst(rst), .req_sel(req_sel),
    .fclk_lvl(fclk_lvl), .sclk_lvl(sclk_lvl),
    .sel(clk_sel), .gap(sw_gap), .busy(sw_busy)
  );

  pm_wr_check #(.CTL_W(CTL_W)) u_wchk (
    .wr_en(wr_en), .wr_data(wr_data),
    .cur_f(fosc_en), .cur_s(sosc_en), .cur_sel(clk_sel),
    .running(st == ST_RUN), .busy(sw_busy),
    .go_deep(go_deep), .go_nap(go_nap), .go_clk(go_clk),
    .tbt_bit(tbt_bit), .illegal(illegal)
  );

  pm_edge_det #(.FALLING(1'b1)) u_tbt_fall (
    .clk(clk), .rst(rst), .lvl(tbt_src_lvl), .pulse(tbt_fall)
  );

  pm_mcycle #(.DIV(MCYC_DIV)) u_mcyc (
    .clk(clk), .rst(rst), .en(cpu_clk_en),
    .lvl(clk_sel ? sclk_lvl : fclk_lvl), .tick(mcyc_tick)
  );

  always_comb begin
    case (st)
      ST_NAP:  mode_q = MD_NAP;
      ST_DEEP: mode_q = MD_DEEP;
      default: begin
        if (clk_sel) mode_q = fosc_en ? MD_SLOW_BOTH : MD_SLOW_LP;
        else         mode_q = sosc_en ? MD_RUN_DUAL  : MD_RUN_FAST;
      end
    endcase
  end

  assign mode       = mode_q;
  assign cpu_clk_en = (st == ST_RUN) && !sw_gap;
  assign per_clk_en = (st != ST_DEEP) && !sw_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_RUN;
      fosc_en      <= 1'b1;
      sosc_en      <= 1'b0;
      req_sel      <= 1'b0;
      err_sticky   <= 1'b0;
      tbt_arm      <= 1'b0;
      tbt_pend     <= 1'b0;
      tbt_irq_set  <= 1'b0;
      wake_service <= 1'b0;
      wake_resume  <= 1'b0;
    end else begin
      wake_service <= 1'b0;
      wake_resume  <= 1'b0;
      tbt_pend     <= 1'b0;
      tbt_irq_set  <= tbt_pend;
      if (illegal) err_sticky <= 1'b1;
      case (st)
        ST_RUN: begin
          if (go_deep) begin
            st      <= ST_DEEP;
            tbt_arm <= tbt_bit;
          end else if (go_nap) begin
            st <= ST_NAP;
          end else if (go_clk) begin
            fosc_en <= wr_data[CB_FAST];
            sosc_en <= wr_data[CB_SLOW];
            req_sel <= wr_data[CB_SEL];
          end
        end
        ST_NAP: begin
          if (irq_any) begin
            st <= ST_RUN;
            if (ime) wake_service <= 1'b1;
            else     wake_resume  <= 1'b1;
          end
        end
        ST_DEEP: begin
          if (tbt_fall) begin
            st       <= ST_RUN;
            sosc_en  <= 1'b0;
            tbt_pend <= tbt_arm;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pwrmode_ctrl_chk.sv
module pwrmode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       fclk_lvl,
  input logic       sclk_lvl,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       fosc_en,
  input logic       sosc_en,
  input logic       clk_sel,
  input logic [2:0] mode,
  input logic       wake_service,
  input logic       wake_resume,
  input logic       tbt_irq_set,
  input logic       err_sticky,
  input logic       mcyc_tick
);
  AST_SEL_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    (clk_sel != $past(clk_sel)) |-> ($past(cpu_clk_en) == 1'b0)); // R4
  AST_SEL_NEW_LOW: assert property (@(posedge clk) disable iff (rst)
    (clk_sel != $past(clk_sel)) |-> ($past(clk_sel ? fclk_lvl : sclk_lvl) == 1'b0)); // R4
  AST_SELECTED_OSC_ON: assert property (@(posedge clk) disable iff (rst)
    (clk_sel ? sosc_en : fosc_en)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(err_sticky) |-> err_sticky); // R6
  AST_NAP_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4) |-> (!cpu_clk_en && per_clk_en)); // R7
  AST_WAKE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wake_service && wake_resume)); // R8
  AST_WAKE_FROM_NAP: assert property (@(posedge clk) disable iff (rst)
    (wake_service || wake_resume) |-> ($past(mode) == 3'd4)); // R8
  AST_DEEP_GATED: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd5) |-> (!cpu_clk_en && !per_clk_en)); // R9
  AST_DEEP_EXIT_FAST: assert property (@(posedge clk) disable iff (rst)
    (($past(mode) == 3'd5) && (mode != 3'd5)) |-> ((mode == 3'd0) && !sosc_en)); // R10
  AST_TBT_AFTER_RETURN: assert property (@(posedge clk) disable iff (rst)
    tbt_irq_set |-> (($past(mode) == 3'd0) && ($past(mode, 2) == 3'd5))); // R11
  AST_TICK_RUNNING: assert property (@(posedge clk) disable iff (rst)
    mcyc_tick |-> $past(cpu_clk_en)); // R12
endmodule

bind pwrmode_ctrl pwrmode_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .fclk_lvl(fclk_lvl), .sclk_lvl(sclk_lvl),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .fosc_en(fosc_en), .sosc_en(sosc_en), .clk_sel(clk_sel), .mode(mode),
  .wake_service(wake_service), .wake_resume(wake_resume),
  .tbt_irq_set(tbt_irq_set), .err_sticky(err_sticky), .mcyc_tick(mcyc_tick)
);

// File: tb/pwrmode_ctrl_tb.sv
module pwrmode_ctrl_tb;
  localparam int FHALF = 1;
  localparam int SHALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic       fclk_lvl = 1'b0, sclk_lvl = 1'b0, tbt_src_lvl = 1'b0;
  logic       irq_any = 1'b0, ime = 1'b0;
  logic       cpu_clk_en, per_clk_en, fosc_en, sosc_en, clk_sel;
  logic [2:0] mode;
  logic       wake_service, wake_resume, tbt_irq_set, err_sticky, mcyc_tick;
  int         n_chk = 0, n_fail = 0;
  int         fcnt = 0, scnt = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pwrmode_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fclk_lvl(fclk_lvl), .sclk_lvl(sclk_lvl), .tbt_src_lvl(tbt_src_lvl),
    .irq_any(irq_any), .ime(ime),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .fosc_en(fosc_en),
    .sosc_en(sosc_en), .clk_sel(clk_sel), .mode(mode),
    .wake_service(wake_service), .wake_resume(wake_resume),
    .tbt_irq_set(tbt_irq_set), .err_sticky(err_sticky), .mcyc_tick(mcyc_tick)
  );

  always @(negedge clk) begin
    fcnt <= (fcnt == FHALF - 1) ? 0 : fcnt + 1;
    if (fcnt == FHALF - 1) fclk_lvl <= ~fclk_lvl;
    scnt <= (scnt == SHALF - 1) ? 0 : scnt + 1;
    if (scnt == SHALF - 1) sclk_lvl <= ~sclk_lvl;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write(input logic [5:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_sel(input logic exp, output bit saw_gap);
    saw_gap = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (clk_sel == exp) break;
      if (!cpu_clk_en) saw_gap = 1'b1;
      @(negedge clk);
    end
    check("R4 switch completes", clk_sel, exp);
  endtask

  task automatic tick_interval(output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (mcyc_tick) break;
    end
    for (int i = 1; i < 300; i++) begin
      @(negedge clk);
      if (mcyc_tick) begin n = i; break; end
    end
  endtask

  task automatic t_reset();
    check("R1 mode", mode, 0);
    check("R1 fosc_en", fosc_en, 1);
    check("R1 sosc_en", sosc_en, 0);
    check("R1 clk_sel", clk_sel, 0);
    check("R1 cpu_clk_en", cpu_clk_en, 1);
    check("R1 per_clk_en", per_clk_en, 1);
    check("R1 err_sticky", err_sticky, 0);
  endtask

  task automatic t_bad_select();
    write(6'h05);
    check("R6 err on select of stopped osc", err_sticky, 1);
    check("R6 mode kept", mode, 0);
    check("R6 sosc kept off", sosc_en, 0);
    repeat (20) @(negedge clk);
    check("R6 clk_sel kept", clk_sel, 0);
  endtask

  task automatic t_to_slow();
    int  n;
    bit  gap;
    write(6'h03);
    check("R2 dual mode", mode, 1);
    check("R2 sosc on", sosc_en, 1);
    tick_interval(n);
    check("R12 fast tick interval", n, 4 * 2 * FHALF);
    write(6'h07);
    check("R4 no immediate select", clk_sel, 0);
    check("R3 still dual during switch", mode, 1);
    wait_sel(1'b1, gap);
    check("R4 gap seen", gap, 1);
    @(negedge clk);
    check("R3 slow both mode", mode, 2);
    tick_interval(n);
    check("R12 slow tick interval", n, 4 * 2 * SHALF);
  endtask

  task automatic t_slow_lp();
    write(6'h05);
    check("R6 slow osc kept on", sosc_en, 1);
    check("R6 mode kept slow", mode, 2);
    write(6'h06);
    check("R5 low-power slow", mode, 3);
    check("R5 fast osc off", fosc_en, 0);
    write(6'h02);
    repeat (20) @(negedge clk);
    check("R6 no switch to stopped fast", clk_sel, 1);
    check("R6 mode kept lp", mode, 3);
    write(6'h10);
    check("R9 deep refused from slow", mode, 3);
  endtask

  task automatic t_nap_resume();
    ime = 1'b0;
    write(6'h08);
    check("R7 nap mode", mode, 4);
    check("R7 cpu gated", cpu_clk_en, 0);
    check("R7 peripherals run", per_clk_en, 1);
    check("R7 fast osc kept off", fosc_en, 0);
    write(6'h07);
    check("R6 write in nap ignored", fosc_en, 0);
    check("R6 still nap", mode, 4);
    irq_any = 1'b1;
    @(negedge clk); irq_any = 1'b0;
    check("R8 back to lp slow", mode, 3);
    check("R8 resume pulse", wake_resume, 1);
    check("R8 no service pulse", wake_service, 0);
    @(negedge clk);
    check("R8 resume one cycle", wake_resume, 0);
  endtask

  task automatic t_back_fast();
    bit gap;
    write(6'h07);
    check("R3 slow both again", mode, 2);
    write(6'h03);
    wait_sel(1'b0, gap);
    @(negedge clk);
    check("R3 back to dual", mode, 1);
    write(6'h01);
    check("R2 back to single", mode, 0);
    check("R2 sosc off", sosc_en, 0);
  endtask

  task automatic t_nap_service();
    ime = 1'b1;
    write(6'h08);
    check("R7 nap from single", mode, 4);
    irq_any = 1'b1;
    @(negedge clk); irq_any = 1'b0;
    check("R8 back to single", mode, 0);
    check("R8 service pulse", wake_service, 1);
    check("R8 no resume pulse", wake_resume, 0);
  endtask

  task automatic t_deep_armed();
    tbt_src_lvl = 1'b0;
    write(6'h30);
    check("R9 deep mode", mode, 5);
    check("R9 cpu gated", cpu_clk_en, 0);
    check("R9 peripherals gated", per_clk_en, 0);
    check("R9 fast osc kept", fosc_en, 1);
    irq_any = 1'b1;
    @(negedge clk); irq_any = 1'b0;
    check("R10 irq ignored", mode, 5);
    tbt_src_lvl = 1'b1;
    @(negedge clk);
    check("R10 rising edge ignored", mode, 5);
    tbt_src_lvl = 1'b0;
    @(negedge clk);
    check("R10 exit on fall", mode, 0);
    check("R11 no latch yet", tbt_irq_set, 0);
    @(negedge clk);
    check("R11 latch pulse", tbt_irq_set, 1);
    @(negedge clk);
    check("R11 latch one cycle", tbt_irq_set, 0);
  endtask

  task automatic t_deep_plain();
    int hits;
    write(6'h03);
    check("R2 dual before deep", mode, 1);
    write(6'h10);
    check("R9 deep from dual", mode, 5);
    check("R9 slow osc kept", sosc_en, 1);
    tbt_src_lvl = 1'b1;
    @(negedge clk);
    tbt_src_lvl = 1'b0;
    hits = 0;
    @(negedge clk);
    check("R10 exit to single", mode, 0);
    check("R10 slow osc off", sosc_en, 0);
    for (int i = 0; i < 3; i++) begin
      if (tbt_irq_set) hits++;
      @(negedge clk);
    end
    check("R11 no latch when disarmed", hits, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bad_select();
    t_to_slow();
    t_slow_lp();
    t_nap_resume();
    t_back_fast();
    t_nap_service();
    t_deep_armed();
    t_deep_plain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule